// File: doc/BRIEF.md
# LIN Header Engine

This block sits next to a byte UART on a single-wire LIN bus and deals with the frame header. In master mode, software raises a one-cycle request. The block then drives a long dominant break, a one-bit recessive delimiter, the sync byte 0x55 and a protected identifier. The identifier is built from a 6-bit value, and the block computes its two parity bits itself. Every bit lasts one period of the bit-rate tick.

In slave mode the block watches the line, sampled once per tick, for a dominant run that reaches a selectable threshold of 10 or 11 bit times. It then checks the sync byte and captures the protected identifier. Data bytes that follow the header are passed out unless a header-only request is pending. Such a request either discards the data of the next frame or, when raised after a header, flushes the received byte and drops back to waiting for a break.

The block also offers two things around the header. A sleep mode raises a wake interrupt either on any dominant bit or only on a dominant pulse of a minimum length. A readback check flags a bit that the bus did not reflect during the block's own transmission, and a control input can turn that check off.

Top module: `lin_hdr_engine`

## Requirements
- R1: After reset, tx is 1 (recessive) and the busy, hdr_only, rx_full, hdr_valid, data_valid, sync_err, mismatch_err and wake_irq outputs are all 0.
- R2: In master mode a request drives, one bit per tick, 13 dominant (0) bits and then one recessive (1) bit. Two UART frames follow, each a 0 start bit, eight data bits LSB first and a 1 stop bit: the first carries 0x55 and the second the protected identifier. Outside a header, tx is 1.
- R3: force_hdr is ignored when master is 0, and while a header is pending or being sent.
- R4: The protected identifier holds tx_id in bits 5:0. Bit 6 is id0^id1^id2^id4 and bit 7 is the inverse of id1^id3^id4^id5.
- R5: A break is recognised once rx has been sampled 0 on 10 consecutive ticks (brk_thr11=0) or on 11 (brk_thr11=1). It is followed by a recessive delimiter.
- R6: If the byte after a break is not 0x55, sync_err pulses for one cycle, no header is reported and the receiver waits for a new break.
- R7: When the identifier's stop bit is sampled, hdr_valid pulses and rx_pid holds the received byte. Each later byte of the frame sets rx_data, pulses data_valid and sets rx_full. A new break clears rx_full.
- R8: A pulse on hdr_only_req while no header has been taken sets hdr_only. The next header clears it, and the data bytes of that frame are neither delivered nor raise rx_full.
- R9: A pulse on hdr_only_req after a header has been taken clears rx_full and leaves hdr_only at 0. The receiver goes back to waiting for a break, so later bytes without a break are not delivered.
- R10: While the block transmits, a tick at which rx differs from the bit being driven pulses mismatch_err, unless mis_dis is 1.
- R11: With sleep=1 and pm_any=1, wake_irq pulses on the first dominant sample after a recessive one.
- R12: With sleep=1 and pm_any=0, wake_irq pulses once when a dominant run reaches WAKE_TICKS samples (default 3). Shorter runs raise nothing, and without sleep no wake interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse per bit time |
| rx | input | 1 | Bus level read back (0 = dominant) |
| master | input | 1 | 1 selects master operation |
| force_hdr | input | 1 | Header transmit request pulse |
| brk_thr11 | input | 1 | 1 selects the 11-bit break threshold |
| hdr_only_req | input | 1 | Header-only request pulse |
| sleep | input | 1 | Low-power mode, receiver held idle |
| pm_any | input | 1 | In sleep, wake on any bus activity |
| mis_dis | input | 1 | Disables the readback mismatch check |
| tx_id | input | 6 | Identifier for transmitted headers |
| tx | output | 1 | Bus drive level |
| busy | output | 1 | Header pending or being sent |
| hdr_valid | output | 1 | Header received pulse |
| rx_pid | output | 8 | Last received protected identifier |
| sync_err | output | 1 | Bad sync byte pulse |
| rx_data | output | 8 | Last received data byte |
| data_valid | output | 1 | Data byte received pulse |
| rx_full | output | 1 | Receive buffer holds a byte |
| mismatch_err | output | 1 | Readback mismatch pulse |
| wake_irq | output | 1 | Wake interrupt pulse |
| hdr_only | output | 1 | Header-only request pending |

## Verification
Two situations are hardest to reach. The first is the readback mismatch, which needs the bus to disagree with the block during one chosen bit of its own header. The bench overlays a dominant level on the looped-back line exactly while its model shows the delimiter bit on the wire. The second is a header-only request raised after a header. The bench streams a full header and a data byte bit by bit, so the receiver sits between bytes, then pulses the request and sends an unbroken byte that must go undelivered.

// File: rtl/lin_hdr_engine.sv
module lin_hdr_engine #(
  parameter int BRK_TX     = 13,
  parameter int WAKE_TICKS = 3,
  parameter int RUN_W      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx,
  input  logic       master,
  input  logic       force_hdr,
  input  logic       brk_thr11,
  input  logic       hdr_only_req,
  input  logic       sleep,
  input  logic       pm_any,
  input  logic       mis_dis,
  input  logic [5:0] tx_id,
  output logic       tx,
  output logic       busy,
  output logic       hdr_valid,
  output logic [7:0] rx_pid,
  output logic       sync_err,
  output logic [7:0] rx_data,
  output logic       data_valid,
  output logic       rx_full,
  output logic       mismatch_err,
  output logic       wake_irq,
  output logic       hdr_only
);
  localparam int TX_BITS = BRK_TX + 21;
  localparam int CW = $clog2(TX_BITS + 1);

  typedef enum logic [2:0] {S_IDLE, S_BRK, S_START, S_DATA, S_STOP} st_t;

  // transmit side
  logic [7:0]         pid_tx;
  logic [TX_BITS-1:0] sh;
  logic [CW-1:0]      cnt;
  logic               pend, act;

  assign pid_tx = {~(tx_id[1] ^ tx_id[3] ^ tx_id[4] ^ tx_id[5]),
                   tx_id[0] ^ tx_id[1] ^ tx_id[2] ^ tx_id[4], tx_id};
  assign tx   = act ? sh[0] : 1'b1;
  assign busy = pend | act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      act <= 1'b0;
      sh <= '1;
      cnt <= '0;
      mismatch_err <= 1'b0;
    end else begin
      mismatch_err <= 1'b0;
      if (force_hdr && master && !pend && !act) pend <= 1'b1;
      if (tick && pend) begin
        sh <= {1'b1, pid_tx, 1'b0, 1'b1, 8'h55, 1'b0, 1'b1, {BRK_TX{1'b0}}};
        act <= 1'b1;
        cnt <= CW'(TX_BITS);
        pend <= 1'b0;
      end else if (tick && act) begin
        mismatch_err <= !mis_dis && (rx != sh[0]);
        sh <= {1'b1, sh[TX_BITS-1:1]};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) act <= 1'b0;
      end
    end
  end

  // dominant run length, shared by break and wake detection
  logic [RUN_W-1:0] run;
  logic [RUN_W:0]   run_nx, thr;

  assign run_nx = {1'b0, run} + 1'b1;
  assign thr = brk_thr11 ? (RUN_W+1)'(11) : (RUN_W+1)'(10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0;
      wake_irq <= 1'b0;
    end else begin
      wake_irq <= 1'b0;
      if (tick) begin
        run <= rx ? '0 : ((&run) ? run : run + 1'b1);
        if (sleep && !rx)
          wake_irq <= pm_any ? (run == '0) : (run_nx == (RUN_W+1)'(WAKE_TICKS));
      end
    end
  end

  // receive side
  st_t        st;
  logic [1:0] byte_ix;
  logic [2:0] nbit;
  logic [7:0] shr;
  logic       flush;

  assign flush = hdr_only_req && (byte_ix == 2'd2) &&
                 (st == S_START || st == S_DATA || st == S_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      byte_ix <= '0;
      nbit <= '0;
      shr <= '0;
      rx_pid <= '0;
      rx_data <= '0;
      rx_full <= 1'b0;
      hdr_only <= 1'b0;
      hdr_valid <= 1'b0;
      sync_err <= 1'b0;
      data_valid <= 1'b0;
    end else begin
      hdr_valid <= 1'b0;
      sync_err <= 1'b0;
      data_valid <= 1'b0;
      if (flush) begin
        st <= S_IDLE;
        rx_full <= 1'b0;
        hdr_only <= 1'b0;
      end else begin
        if (hdr_only_req) hdr_only <= 1'b1;
        if (sleep) st <= S_IDLE;
        else if (tick) begin
          case (st)
            S_IDLE: if (!rx && run_nx >= thr) st <= S_BRK;
            S_BRK: if (rx) begin
              st <= S_START;
              byte_ix <= '0;
              rx_full <= 1'b0;
            end
            S_START: if (!rx) begin
              st <= S_DATA;
              nbit <= '0;
            end
            S_DATA: begin
              shr <= {rx, shr[7:1]};
              nbit <= nbit + 1'b1;
              if (nbit == 3'd7) st <= S_STOP;
            end
            S_STOP: begin
              if (!rx) st <= (run_nx >= thr) ? S_BRK : S_IDLE;
              else if (byte_ix == 2'd0) begin
                if (shr == 8'h55) begin
                  byte_ix <= 2'd1;
                  st <= S_START;
                end else begin
                  sync_err <= 1'b1;
                  st <= S_IDLE;
                end
              end else if (byte_ix == 2'd1) begin
                rx_pid <= shr;
                hdr_valid <= 1'b1;
                if (hdr_only) begin
                  hdr_only <= 1'b0;
                  st <= S_IDLE;
                end else begin
                  byte_ix <= 2'd2;
                  st <= S_START;
                end
              end else begin
                rx_data <= shr;
                data_valid <= 1'b1;
                rx_full <= 1'b1;
                st <= S_START;
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  assert_force_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(master && force_hdr));
  assert_mis_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_dis && $past(mis_dis)) |-> !mismatch_err);
  assert_wake_in_sleep_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> $past(sleep));
  assert_sync_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> !hdr_valid);
  assert_hdr_only_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !hdr_only_req) |-> !hdr_only);
  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_only_req && byte_ix == 2'd2 && st != S_IDLE && st != S_BRK) |=>
      (!rx_full && st == S_IDLE && !hdr_only));
endmodule

// File: tb/lin_hdr_engine_test.sv
module lin_hdr_engine_test;
  logic clk = 0, rst_n = 0, tick = 0;
  logic drv_rx = 1, bus_dom = 0;
  logic master = 0, force_hdr = 0, brk_thr11 = 0, hdr_only_req = 0;
  logic sleep = 0, pm_any = 0, mis_dis = 0;
  logic [5:0] tx_id = 0;
  logic tx, busy, hdr_valid, sync_err, data_valid, rx_full, mismatch_err, wake_irq, hdr_only;
  logic [7:0] rx_pid, rx_data;
  logic rx;
  int tests = 0, fails = 0, tdiv = 0;
  int n_hdr = 0, n_sync = 0, n_data = 0, n_mis = 0, n_wake = 0;
  bit mq[$];
  bit mact = 0, mpend = 0;

  assign rx = drv_rx & tx & ~bus_dom;

  lin_hdr_engine uut (.clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx), .master(master),
    .force_hdr(force_hdr), .brk_thr11(brk_thr11), .hdr_only_req(hdr_only_req),
    .sleep(sleep), .pm_any(pm_any), .mis_dis(mis_dis), .tx_id(tx_id), .tx(tx),
    .busy(busy), .hdr_valid(hdr_valid), .rx_pid(rx_pid), .sync_err(sync_err),
    .rx_data(rx_data), .data_valid(data_valid), .rx_full(rx_full),
    .mismatch_err(mismatch_err), .wake_irq(wake_irq), .hdr_only(hdr_only));

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  function automatic logic [7:0] pid_of(input logic [5:0] id);
    logic p0, p1;
    p0 = ^(id & 6'b010111);
    p1 = ~^(id & 6'b111010);
    return {p1, p0, id};
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      tdiv = 0;
      tick = 0;
    end else begin
      tdiv = (tdiv + 1) % 4;
      tick = (tdiv == 0);
    end
  end

  // behavioural model of the transmit line (R2, R3)
  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      mact = 0;
      mpend = 0;
    end else begin
      automatic bit was_busy = mpend || mact;
      if (tick && mpend) begin
        automatic logic [7:0] p = pid_of(tx_id);
        mq.delete();
        repeat (13) mq.push_back(1'b0);
        mq.push_back(1'b1);
        mq.push_back(1'b0);
        for (int i = 0; i < 8; i++) mq.push_back(((8'h55 >> i) & 1) != 0);
        mq.push_back(1'b1);
        mq.push_back(1'b0);
        for (int i = 0; i < 8; i++) mq.push_back(p[i]);
        mq.push_back(1'b1);
        mact = 1;
        mpend = 0;
      end else if (tick && mact) begin
        void'(mq.pop_front());
        if (mq.size() == 0) mact = 0;
      end
      if (force_hdr && master && !was_busy) mpend = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(tx === (mact ? mq[0] : 1'b1), "R2 tx line", tx, mact ? mq[0] : 1'b1);
      check(busy === (mact || mpend), "R3 busy", busy, mact || mpend);
      if (hdr_valid) n_hdr++;
      if (sync_err) n_sync++;
      if (data_valid) n_data++;
      if (mismatch_err) n_mis++;
      if (wake_irq) n_wake++;
    end
  end

  task automatic wait_tick();
    do @(posedge clk); while (!tick);
    @(negedge clk);
  endtask

  task automatic bit_out(input bit b);
    drv_rx = b;
    wait_tick();
  endtask

  task automatic frame(input logic [7:0] b);
    bit_out(0);
    for (int i = 0; i < 8; i++) bit_out(b[i]);
    bit_out(1);
  endtask

  task automatic header(input int nbrk, input logic [7:0] s, input logic [7:0] p);
    repeat (nbrk) bit_out(0);
    bit_out(1);
    frame(s);
    frame(p);
  endtask

  task automatic idle(input int n);
    repeat (n) bit_out(1);
  endtask

  task automatic pulse_force();
    force_hdr = 1;
    @(negedge clk);
    force_hdr = 0;
  endtask

  task automatic pulse_hdr_only();
    hdr_only_req = 1;
    @(negedge clk);
    hdr_only_req = 0;
  endtask

  task automatic master_hdr(input logic [5:0] id, input bit dom_delim);
    tx_id = id;
    pulse_force();
    if (dom_delim) begin
      do @(negedge clk); while (!(mact && mq.size() == 21));
      bus_dom = 1;
      do @(negedge clk); while (mq.size() != 20);
      bus_dom = 0;
    end else begin
      idle(5);
      pulse_force();
    end
    idle(40);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int h, s, d, m, w;
    repeat (4) @(negedge clk);
    rst_n = 1;
    check(tx === 1 && busy === 0 && hdr_only === 0 && rx_full === 0, "R1 reset",
          {tx, busy, hdr_only, rx_full}, 4'b1000);
    check({hdr_valid, data_valid, sync_err, mismatch_err, wake_irq} === 0, "R1 pulses",
          {hdr_valid, data_valid, sync_err, mismatch_err, wake_irq}, 0);
    idle(3);

    h = n_hdr;
    header(10, 8'h55, pid_of(6'h12));
    idle(2);
    check(n_hdr - h == 1, "R5 10-bit break", n_hdr - h, 1);
    check(rx_pid == pid_of(6'h12), "R7 rx_pid", rx_pid, pid_of(6'h12));

    brk_thr11 = 1;
    h = n_hdr;
    header(10, 8'h55, pid_of(6'h05));
    idle(2);
    check(n_hdr - h == 0, "R5 10 lows below 11 threshold", n_hdr - h, 0);
    header(11, 8'h55, pid_of(6'h05));
    idle(2);
    check(n_hdr - h == 1, "R5 11-bit break", n_hdr - h, 1);
    brk_thr11 = 0;

    h = n_hdr; s = n_sync;
    header(13, 8'h54, pid_of(6'h07));
    idle(2);
    check(n_sync - s == 1 && n_hdr - h == 0, "R6 bad sync", {n_sync - s, n_hdr - h}, 16'h1_0);

    pulse_hdr_only();
    check(hdr_only === 1, "R8 hdr_only set", hdr_only, 1);
    h = n_hdr; d = n_data;
    header(13, 8'h55, pid_of(6'h21));
    frame(8'h3C);
    idle(2);
    check(n_hdr - h == 1 && hdr_only === 0, "R8 auto clear", {n_hdr - h, hdr_only}, 2);
    check(n_data - d == 0 && rx_full === 0, "R8 data discarded", n_data - d, 0);

    d = n_data;
    header(13, 8'h55, pid_of(6'h2A));
    frame(8'hA5);
    idle(2);
    check(n_data - d == 1 && rx_data == 8'hA5 && rx_full === 1, "R7 data byte", rx_data, 8'hA5);

    pulse_hdr_only();
    check(rx_full === 0 && hdr_only === 0, "R9 flush", {rx_full, hdr_only}, 0);
    d = n_data;
    frame(8'h22);
    idle(2);
    check(n_data - d == 0, "R9 byte after flush dropped", n_data - d, 0);

    master = 1;
    for (int k = 0; k < 3; k++) begin
      automatic logic [5:0] id = (k == 0) ? 6'h3C : (k == 1) ? 6'h3F : 6'h00;
      h = n_hdr; m = n_mis;
      master_hdr(id, 0);
      check(n_hdr - h == 1, "R2 own header heard", n_hdr - h, 1);
      check(rx_pid == pid_of(id), "R4 parity", rx_pid, pid_of(id));
      check(n_mis - m == 0, "R10 clean readback", n_mis - m, 0);
    end

    m = n_mis;
    master_hdr(6'h11, 1);
    check(n_mis - m == 1, "R10 mismatch flagged", n_mis - m, 1);
    mis_dis = 1;
    m = n_mis;
    master_hdr(6'h11, 1);
    check(n_mis - m == 0, "R10 mismatch disabled", n_mis - m, 0);
    mis_dis = 0;

    master = 0;
    pulse_force();
    idle(5);
    check(busy === 0 && tx === 1, "R3 slave ignores force", busy, 0);

    sleep = 1; pm_any = 1;
    idle(2);
    w = n_wake;
    bit_out(0);
    idle(2);
    check(n_wake - w == 1, "R11 any activity wakes", n_wake - w, 1);
    pm_any = 0;
    w = n_wake;
    bit_out(0);
    idle(2);
    check(n_wake - w == 0, "R12 short pulse ignored", n_wake - w, 0);
    repeat (3) bit_out(0);
    idle(2);
    check(n_wake - w == 1, "R12 wake pulse", n_wake - w, 1);
    w = n_wake;
    repeat (6) bit_out(0);
    idle(2);
    check(n_wake - w == 1, "R12 one wake per pulse", n_wake - w, 1);
    sleep = 0;
    w = n_wake;
    repeat (5) bit_out(0);
    idle(2);
    check(n_wake - w == 0, "R12 no wake when awake", n_wake - w, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule